// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Emulator

This block acts as the device side of a three-wire serial EEPROM with 16-bit words. The word store lives in ordinary registers, and the memory holds 64 or 256 words depending on the address width. A host drives a select line, a serial clock and a serial data input. The block samples all three in the system clock domain, assembles each instruction from the bits taken on rising serial-clock edges, and carries it out against the word store. It returns read data and a programming status on a single data output.

Reads, single-word programming, single-word erase, whole-array fill and whole-array erase are all supported. A write-enable latch guards every command that changes the store. Programming time is modelled by a down-counter in system clocks. While that counter runs, the block refuses new instructions and shows busy on the data output.

Top module: `mw_eeprom_emu`

## Requirements
- R1: While select is low, `sdo_o` is low. After reset the write-enable latch is clear and every word reads 0xFFFF.
- R2: With select high, the block samples `sdi_i` on each rising edge of `sclk_i`. Zeros before the first 1 are ignored. That first 1 is the start bit, followed by a 2-bit opcode and then ADDR_W address bits, both MSB first.
- R3: Opcode 2'b10 reads. After the last address bit `sdo_o` is 0 for one bit time. Each later rising edge then presents the next bit of the addressed word, MSB first, for 16 bits.
- R4: Opcode 2'b01 is followed by 16 data bits, MSB first, and stores that word at the address.
- R5: Opcode 2'b11 sets the addressed word to 0xFFFF.
- R6: For opcode 2'b00, address bits [ADDR_W-1:ADDR_W-2] select the command and the lower address bits are ignored. 2'b11 enables writes and 2'b00 disables them. 2'b10 sets every word to 0xFFFF. 2'b01 takes 16 data bits and writes them to every word.
- R7: A write, erase, fill or erase-all received while the write-enable latch is clear changes no word and starts no busy period.
- R8: An accepted programming command starts a busy period of BUSY_CYCLES system clocks. Between instructions with select high, `sdo_o` is 0 while busy and 1 when ready.
- R9: A start bit that arrives during a busy period is ignored, so no command from that frame takes effect.
- R10: Lowering select part-way through an instruction discards it, nothing is programmed, and the block waits for a new start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_i | input | 1 | Device select, active high |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial instruction and data input |
| sdo_o | output | 1 | Serial read data and ready/busy status |

## Verification
The bench targets the moments where the framing can slip. It sends leading zeros before the start bit, checks the single dummy zero ahead of read data, and cuts select part-way through a write data field. A decoder that miscounted any of these would shift every returned bit or commit a half-received word. It also sends programming commands with the latch clear and again after a disable, where a design that ignored the latch would alter stored words or go busy. A full write frame sent during a busy period checks that a design accepting start bits while busy cannot corrupt the target word.

// File: rtl/mw_pkg.sv
// Shared types for the serial EEPROM emulator.
// Assumes: words are 16 bits wide; opcode values follow the serial protocol.
package mw_pkg;
    localparam int WORD_W = 16;

    localparam logic [1:0] OP_EXT   = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_ERASE = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_DOUT,
        ST_HOLD
    } mw_state_e;

    typedef enum logic [2:0] {
        PK_WRITE,
        PK_ERASE,
        PK_ERAL,
        PK_WRAL,
        PK_EWEN,
        PK_EWDS
    } mw_prog_e;
endpackage

// File: rtl/mw_input_sync.sv
// Brings select, serial clock and serial data into the system clock domain
// through a double flop stage. Reports one pulse per serial clock rising edge.
// Assumes: the serial clock is much slower than the system clock.
module mw_input_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic sclk_i,
    input  logic sdi_i,
    output logic sel_s,
    output logic sdi_s,
    output logic rise
);
    logic [STAGES-1:0] sel_q, sclk_q, sdi_q;
    logic              sclk_d;

    // Synchronizer chains and serial clock history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            sclk_q <= '0;
            sdi_q  <= '0;
            sclk_d <= 1'b0;
        end else begin
            sel_q  <= {sel_q[STAGES-2:0],  sel_i};
            sclk_q <= {sclk_q[STAGES-2:0], sclk_i};
            sdi_q  <= {sdi_q[STAGES-2:0],  sdi_i};
            sclk_d <= sclk_q[STAGES-1];
        end
    end

    // Synchronized levels and rising-edge pulse.
    always_comb begin
        sel_s = sel_q[STAGES-1];
        sdi_s = sdi_q[STAGES-1];
        rise  = sclk_q[STAGES-1] & ~sclk_d;
    end
endmodule

// File: rtl/mw_cmd_fsm.sv
// Instruction decoder: finds the start bit, shifts in opcode, address and
// data, issues programming commands and shifts out read data.
// Assumes: inputs are already synchronized; rise is a one-cycle pulse.
module mw_cmd_fsm
    import mw_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_s,
    input  logic              sdi_s,
    input  logic              rise,
    input  logic              busy,
    input  logic [WORD_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              cmd_vld,
    output mw_prog_e          cmd_kind,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [WORD_W-1:0] cmd_data,
    output logic              out_bit,
    output logic              idle
);
    localparam int CNT_W = 5;
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] DOUT_LAST = CNT_W'(WORD_W);

    mw_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [1:0]        op_sr;
    logic [ADDR_W-1:0] addr_sr;
    logic [WORD_W-1:0] data_sr;
    logic [WORD_W:0]   out_sr;
    logic [ADDR_W-1:0] addr_full;
    logic [1:0]        ext_sel;

    // Address including the bit being sampled on this edge.
    always_comb begin
        addr_full = {addr_sr[ADDR_W-2:0], sdi_s};
        ext_sel   = addr_full[ADDR_W-1 -: 2];
        rd_addr   = addr_full;
        out_bit   = out_sr[WORD_W];
        idle      = (state == ST_IDLE);
    end

    // Main sequencer, advanced on serial clock rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            op_sr    <= '0;
            addr_sr  <= '0;
            data_sr  <= '0;
            out_sr   <= '0;
            cmd_vld  <= 1'b0;
            cmd_kind <= PK_EWDS;
            cmd_addr <= '0;
            cmd_data <= '0;
        end else begin
            cmd_vld <= 1'b0;
            if (!sel_s) begin
                state  <= ST_IDLE;
                cnt    <= '0;
                out_sr <= '0;
            end else if (rise) begin
                unique case (state)
                    ST_IDLE: begin
                        if (sdi_s && !busy) begin
                            state <= ST_OPC;
                            cnt   <= '0;
                        end
                    end
                    ST_OPC: begin
                        op_sr <= {op_sr[0], sdi_s};
                        if (cnt == CNT_W'(1)) begin
                            state <= ST_ADDR;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_ADDR: begin
                        addr_sr <= addr_full;
                        if (cnt == ADDR_LAST) begin
                            cnt      <= '0;
                            cmd_addr <= addr_full;
                            unique case (op_sr)
                                OP_READ: begin
                                    out_sr <= {1'b0, rd_data};
                                    state  <= ST_DOUT;
                                end
                                OP_WRITE: begin
                                    cmd_kind <= PK_WRITE;
                                    state    <= ST_DATA;
                                end
                                OP_ERASE: begin
                                    cmd_kind <= PK_ERASE;
                                    cmd_vld  <= 1'b1;
                                    state    <= ST_HOLD;
                                end
                                default: begin
                                    unique case (ext_sel)
                                        2'b11: begin
                                            cmd_kind <= PK_EWEN;
                                            cmd_vld  <= 1'b1;
                                            state    <= ST_HOLD;
                                        end
                                        2'b10: begin
                                            cmd_kind <= PK_ERAL;
                                            cmd_vld  <= 1'b1;
                                            state    <= ST_HOLD;
                                        end
                                        2'b01: begin
                                            cmd_kind <= PK_WRAL;
                                            state    <= ST_DATA;
                                        end
                                        default: begin
                                            cmd_kind <= PK_EWDS;
                                            cmd_vld  <= 1'b1;
                                            state    <= ST_HOLD;
                                        end
                                    endcase
                                end
                            endcase
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        data_sr <= {data_sr[WORD_W-2:0], sdi_s};
                        if (cnt == DATA_LAST) begin
                            cmd_data <= {data_sr[WORD_W-2:0], sdi_s};
                            cmd_vld  <= 1'b1;
                            state    <= ST_HOLD;
                            cnt      <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DOUT: begin
                        out_sr <= {out_sr[WORD_W-1:0], 1'b0};
                        if (cnt == DOUT_LAST) begin
                            state <= ST_HOLD;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_s |=> state == ST_IDLE); // R10
    AST_BUSY_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && busy) |=> state == ST_IDLE); // R9
endmodule

// File: rtl/mw_word_store.sv
// Word array, write-enable latch and programming busy timer.
// Assumes: cmd_vld is a one-cycle pulse; the decoder issues no command while busy.
module mw_word_store
    import mw_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int BUSY_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_vld,
    input  mw_prog_e          cmd_kind,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [WORD_W-1:0] cmd_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              busy
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [WORD_W-1:0] mem [DEPTH];
    logic              wel;
    logic [CNT_W-1:0]  busy_cnt;
    logic              prog_ok;

    // A programming command that the latch lets through.
    always_comb begin
        prog_ok = cmd_vld && wel && (cmd_kind != PK_EWEN) && (cmd_kind != PK_EWDS);
        busy    = (busy_cnt != '0);
        rd_data = mem[rd_addr];
    end

    // Write-enable latch updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel <= 1'b0;
        end else if (cmd_vld && cmd_kind == PK_EWEN) begin
            wel <= 1'b1;
        end else if (cmd_vld && cmd_kind == PK_EWDS) begin
            wel <= 1'b0;
        end
    end

    // Busy timer standing in for programming time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (prog_ok) begin
            busy_cnt <= CNT_W'(BUSY_CYCLES);
        end else if (busy_cnt != '0) begin
            busy_cnt <= busy_cnt - 1'b1;
        end
    end

    // Word array: reset to erased, then single-word or whole-array updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (prog_ok) begin
            unique case (cmd_kind)
                PK_WRITE: mem[cmd_addr] <= cmd_data;
                PK_ERASE: mem[cmd_addr] <= '1;
                PK_ERAL:  for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
                PK_WRAL:  for (int i = 0; i < DEPTH; i++) mem[i] <= cmd_data;
                default: ;
            endcase
        end
    end

    AST_LOCKED_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!wel && busy_cnt == '0) |=> busy_cnt == '0); // R7
    AST_WEL_SET_BY_EWEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> $past(cmd_vld && cmd_kind == PK_EWEN)); // R6
endmodule

// File: rtl/mw_eeprom_emu.sv
// Top of the serial EEPROM device emulator: synchronizer, instruction
// decoder and word store, plus the registered serial data output.
// Assumes: ADDR_W is 6 or 8; the host serial clock is slower than clk/8.
module mw_eeprom_emu #(
    parameter int ADDR_W      = 6,
    parameter int BUSY_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic sclk_i,
    input  logic sdi_i,
    output logic sdo_o
);
    import mw_pkg::*;

    logic              sel_s, sdi_s, rise;
    logic              busy, cmd_vld, out_bit, idle;
    mw_prog_e          cmd_kind;
    logic [ADDR_W-1:0] cmd_addr, rd_addr;
    logic [WORD_W-1:0] cmd_data, rd_data;
    logic              sdo_q;

    mw_input_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .sclk_i(sclk_i), .sdi_i(sdi_i),
        .sel_s(sel_s), .sdi_s(sdi_s), .rise(rise)
    );

    mw_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .sdi_s(sdi_s), .rise(rise),
        .busy(busy), .rd_data(rd_data), .rd_addr(rd_addr), .cmd_vld(cmd_vld),
        .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .out_bit(out_bit), .idle(idle)
    );

    mw_word_store #(.ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY_CYCLES)) u_store (
        .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_kind(cmd_kind),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy)
    );

    // Output register: status when idle, read bits otherwise, low when deselected.
    always_ff @(posedge clk) begin
        if (!rst_n) sdo_q <= 1'b0;
        else        sdo_q <= sel_s && (idle ? ~busy : out_bit);
    end

    assign sdo_o = sdo_q;

    AST_SDO_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_s |=> !sdo_o); // R1
endmodule

// File: tb/test_mw_eeprom_emu.sv
module test_mw_eeprom_emu;
    localparam int AW   = 6;
    localparam int BUSY = 600;
    localparam int NW   = 1 << AW;

    logic clk = 1'b0, rst_n = 1'b0, sel = 1'b0, sclk = 1'b0, sdi = 1'b0;
    logic sdo;
    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic [15:0] model [NW];

    mw_eeprom_emu #(.ADDR_W(AW), .BUSY_CYCLES(BUSY)) i_mw_eeprom_emu (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .sclk_i(sclk), .sdi_i(sdi), .sdo_o(sdo)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cs_on();
        @(negedge clk) sel = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic cs_off();
        @(negedge clk) begin sel = 1'b0; sdi = 1'b0; sclk = 1'b0; end
        repeat (8) @(negedge clk);
    endtask

    task automatic pulse();
        sclk = 1'b1;
        repeat (6) @(negedge clk);
        sclk = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = v[i];
            pulse();
        end
    endtask

    // Raise select, sample status, poll until ready.
    task automatic status(output bit first, output int waited);
        cs_on();
        first = sdo;
        waited = 0;
        while (sdo !== 1'b1 && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        cs_off();
    endtask

    task automatic prog(input logic [1:0] op, input logic [AW-1:0] a, input bit has_data,
                        input logic [15:0] d);
        cs_on();
        send_bits({29'd0, 1'b1, op}, 3);
        send_bits(32'(a), AW);
        if (has_data) send_bits(32'(d), 16);
        cs_off();
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [15:0] q, output bit dummy);
        cs_on();
        send_bits(32'b110, 3);
        send_bits(32'(a), AW);
        dummy = sdo;
        for (int i = 15; i >= 0; i--) begin
            pulse();
            q[i] = sdo;
        end
        cs_off();
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input string req);
        logic [15:0] q;
        bit dz;
        rd(a, q, dz);
        chk(dz == 1'b0, "R3 dummy", int'(dz), 0);
        chk(q == model[a], req, int'(q), int'(model[a]));
    endtask

    function automatic logic [AW-1:0] ext(input logic [1:0] s);
        return {s, {(AW-2){1'b0}}};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        bit first;
        int waited;
        logic [15:0] q;
        bit dz;
        void'($urandom(32'h1c0de));
        for (int i = 0; i < NW; i++) model[i] = 16'hFFFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(sdo == 1'b0, "R1 deselected", int'(sdo), 0);

        status(first, waited);
        chk(first == 1'b1, "R8 ready at start", int'(first), 1);
        rd_chk(6'd5, "R1 erased after reset");
        rd_chk(6'd63, "R1 erased after reset");

        // R7: latch clear after reset
        prog(2'b01, 6'd5, 1'b1, 16'h1234);
        status(first, waited);
        chk(first == 1'b1, "R7 no busy when locked", int'(first), 1);
        rd_chk(6'd5, "R7 locked write ignored");

        // R6: enable
        prog(2'b00, ext(2'b11), 1'b0, 16'h0);
        status(first, waited);
        chk(first == 1'b1, "R6 enable does not busy", int'(first), 1);

        // R2: leading zeros before start bit
        cs_on();
        send_bits(32'b000, 3);
        send_bits(32'b101, 3);
        send_bits(32'd10, AW);
        send_bits(32'hA5C3, 16);
        cs_off();
        model[10] = 16'hA5C3;
        status(first, waited);
        chk(first == 1'b0, "R8 busy after write", int'(first), 0);
        chk(waited > 500 && waited < BUSY, "R8 busy length", waited, BUSY);
        rd_chk(6'd10, "R2 leading zeros");

        // R4: random writes
        for (int n = 0; n < 12; n++) begin
            logic [AW-1:0] a;
            logic [15:0] d;
            a = AW'($urandom_range(0, NW - 1));
            d = 16'($urandom);
            prog(2'b01, a, 1'b1, d);
            model[a] = d;
            status(first, waited);
            rd_chk(a, "R4 random write");
        end

        // R9: a full frame while busy is ignored
        prog(2'b01, 6'd20, 1'b1, 16'h1111);
        model[20] = 16'h1111;
        prog(2'b01, 6'd21, 1'b1, 16'h2222);
        status(first, waited);
        rd_chk(6'd21, "R9 start ignored while busy");
        rd_chk(6'd20, "R4 write before busy frame");

        // R5: erase
        prog(2'b11, 6'd10, 1'b0, 16'h0);
        model[10] = 16'hFFFF;
        status(first, waited);
        chk(first == 1'b0, "R8 busy after erase", int'(first), 0);
        rd_chk(6'd10, "R5 erase");

        // R10: abort mid data
        cs_on();
        send_bits(32'b101, 3);
        send_bits(32'd3, AW);
        send_bits(32'h00, 8);
        cs_off();
        status(first, waited);
        chk(first == 1'b1, "R10 abort no busy", int'(first), 1);
        rd_chk(6'd3, "R10 abort no write");

        // R6: fill all
        prog(2'b00, ext(2'b01) | 6'd7, 1'b1, 16'h5A5A);
        for (int i = 0; i < NW; i++) model[i] = 16'h5A5A;
        status(first, waited);
        chk(first == 1'b0, "R8 busy after fill", int'(first), 0);
        rd_chk(6'd0, "R6 fill all");
        rd_chk(6'd63, "R6 fill all");

        // R6: erase all
        prog(2'b00, ext(2'b10), 1'b0, 16'h0);
        for (int i = 0; i < NW; i++) model[i] = 16'hFFFF;
        status(first, waited);
        rd_chk(6'd1, "R6 erase all");
        rd_chk(6'd40, "R6 erase all");

        // R6/R7: disable then write ignored
        prog(2'b00, ext(2'b00), 1'b0, 16'h0);
        prog(2'b01, 6'd7, 1'b1, 16'h0BAD);
        status(first, waited);
        chk(first == 1'b1, "R7 no busy after disable", int'(first), 1);
        rd(6'd7, q, dz);
        chk(q == 16'hFFFF, "R6 disable blocks write", int'(q), 16'hFFFF);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule